// File: doc/BRIEF.md
# Collatz Predecessor Streaming Engine

This block walks the inverse Collatz graph one node at a time. It takes 32-bit unsigned values `y` from an input queue and, for each one, writes the values that map onto `y` under one forward Collatz step to an output queue. Doubling always gives a candidate, `2y`. A second candidate, `(y-1)/3`, exists only when `y` leaves remainder 4 after division by 6. Each candidate is checked against a programmable upper bound and dropped if it is out of range. The odd candidate is also dropped when it equals 1, so the trivial 1-4-2 loop is not entered again.

Both sides are plain FIFO handshakes. On the input side the engine issues a pop, and the read data arrives one cycle later. On the output side it issues a push, which is only taken while the queue is not full. Feeding the outputs back into the input is left to the surrounding system. The block emits zero, one or two words per input. The doubled value always comes first. A full output queue stalls the engine without losing any result.

Top module: `collatz_pred_engine`

## Requirements
- R1: For an input `y`, the word `2y` is pushed when `y` is below 2^31 and `2y <= limit`; otherwise it is not pushed.
- R2: The word `(y-1)/3` is pushed only when `y mod 6 == 4`, the result is not 1 and the result is `<= limit`; for any other `y` no second word appears.
- R3: When both words are pushed for one input, `2y` is pushed before `(y-1)/3`. All words for one input are pushed before any word for the next input.
- R4: A pop is issued only while `enable` is high, the engine is idle and `in_empty` is low. The popped data is taken in the cycle after the pop. Two consecutive cycles never both pop.
- R5: While `out_full` is high, `out_push` stays low and `out_data` holds its value. Every pending word is pushed once the queue has room, and none is lost or repeated.
- R6: With `out_full` held low and inputs always available, each input takes at most four clock cycles from its pop to its last push.
- R7: With `enable` low, no new pop is issued. Words already pending for a popped input are still pushed.
- R8: After a synchronous active-low reset, `in_pop` and `out_push` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Allows new inputs to be taken |
| limit | input | 32 | Largest value that may be emitted |
| in_empty | input | 1 | Input queue has no data |
| in_pop | output | 1 | Read request to the input queue |
| in_data | input | 32 | Input queue read data, valid one cycle after `in_pop` |
| out_full | input | 1 | Output queue cannot accept a word |
| out_push | output | 1 | Write strobe to the output queue |
| out_data | output | 32 | Word written to the output queue |

## Verification
Two events can fall in the same cycle here: the output queue turns full, and the engine reaches one of its two push states. This is most critical for a pending odd word that follows a doubled word. The bench sets up this collision by driving `out_full` from a pseudo-random pattern while a stream of inputs with two results each is running. It also holds `out_full` high at the moment `enable` is dropped. A scoreboard then confirms that every expected word appears exactly once and in order, so a retried push that is lost, duplicated or reordered is caught as a value mismatch or as a leftover entry.

// File: rtl/cpe_pkg.sv
// Package: shared state encoding for the Collatz predecessor engine.
// Assumes: users import it before declaring controller state.
package cpe_pkg;

    // Controller state: idle, read-latency wait, doubled-word push, odd-word push.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_EVEN = 2'd2,
        ST_ODD  = 2'd3
    } cpe_state_t;

endpackage

// File: rtl/cpe_pred_calc.sv
// Module: cpe_pred_calc
// Purely combinational. From a value y it forms both inverse-Collatz
// candidates and decides whether each may be emitted under the bound.
// Assumes: y is unsigned; WIDTH is at least 4.
module cpe_pred_calc #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] y,
    input  logic [WIDTH-1:0] limit,
    output logic [WIDTH-1:0] even_val,
    output logic             even_ok,
    output logic [WIDTH-1:0] odd_val,
    output logic             odd_ok
);
    localparam logic [WIDTH-1:0] SIX   = WIDTH'(6);
    localparam logic [WIDTH-1:0] FOUR  = WIDTH'(4);
    localparam logic [WIDTH-1:0] THREE = WIDTH'(3);
    localparam logic [WIDTH-1:0] ONE   = WIDTH'(1);

    logic [WIDTH-1:0] rem6;

    // Doubled candidate: legal when the shift drops no bit and stays in bound.
    always_comb begin
        even_val = {y[WIDTH-2:0], 1'b0};
        even_ok  = !y[WIDTH-1] && (even_val <= limit);
    end

    // Odd candidate: exists only for y congruent to 4 mod 6, excluding the value 1.
    always_comb begin
        rem6    = y % SIX;
        odd_val = (y - ONE) / THREE;
        odd_ok  = (rem6 == FOUR) && (odd_val != ONE) && (odd_val <= limit);
    end

endmodule

// File: rtl/cpe_ctrl.sv
// Module: cpe_ctrl
// Sequencer for the engine. It pops the input queue, waits one cycle
// for the read data, captures the candidates, then pushes the doubled
// word and the odd word in that order. A full output queue freezes it.
// Assumes: the input queue returns data exactly one cycle after a pop;
// the candidate inputs are a combinational function of that data.
module cpe_ctrl
    import cpe_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [WIDTH-1:0] limit,
    input  logic             in_empty,
    output logic             in_pop,
    input  logic [WIDTH-1:0] cand_even,
    input  logic             cand_even_ok,
    input  logic [WIDTH-1:0] cand_odd,
    input  logic             cand_odd_ok,
    input  logic             out_full,
    output logic             out_push,
    output logic [WIDTH-1:0] out_data
);
    cpe_state_t       state_q, state_d;
    logic [WIDTH-1:0] even_q, odd_q;
    logic             odd_ok_q;
    logic             emitting;

    // Next-state logic: take a new word only from idle, skip empty pushes.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (enable && !in_empty) state_d = ST_WAIT;
            ST_WAIT: begin
                if (cand_even_ok)     state_d = ST_EVEN;
                else if (cand_odd_ok) state_d = ST_ODD;
                else                  state_d = ST_IDLE;
            end
            ST_EVEN: if (!out_full) state_d = odd_ok_q ? ST_ODD : ST_IDLE;
            ST_ODD:  if (!out_full) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Candidate capture in the wait cycle, when the popped data is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            even_q   <= '0;
            odd_q    <= '0;
            odd_ok_q <= 1'b0;
        end else if (state_q == ST_WAIT) begin
            even_q   <= cand_even;
            odd_q    <= cand_odd;
            odd_ok_q <= cand_odd_ok;
        end
    end

    // Queue strobes and output word selection.
    always_comb begin
        emitting = (state_q == ST_EVEN) || (state_q == ST_ODD);
        in_pop   = (state_q == ST_IDLE) && enable && !in_empty;
        out_push = emitting && !out_full;
        out_data = (state_q == ST_ODD) ? odd_q : even_q;
    end

    // R4
    pop_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_pop |=> !in_pop);

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emitting && out_full) |=> (emitting && $stable(out_data)));

    // R1
    even_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_push && state_q == ST_EVEN) |-> (out_data <= limit && !out_data[0]));

    // R2
    odd_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_push && state_q == ST_ODD) |->
            (out_data[0] && out_data != WIDTH'(1) && out_data <= limit));

    // R3
    odd_after_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ODD && $past(state_q) != ST_ODD) |->
            ($past(state_q) == ST_EVEN || $past(state_q) == ST_WAIT));

endmodule

// File: rtl/collatz_pred_engine.sv
// Module: collatz_pred_engine (top)
// Streams inverse-Collatz predecessors from an input queue to an output
// queue. The candidate arithmetic is combinational on the popped data,
// and the sequencing is done by cpe_ctrl.
// Assumes: input queue read latency of one cycle; synchronous reset.
module collatz_pred_engine #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [WIDTH-1:0] limit,
    input  logic             in_empty,
    output logic             in_pop,
    input  logic [WIDTH-1:0] in_data,
    input  logic             out_full,
    output logic             out_push,
    output logic [WIDTH-1:0] out_data
);
    logic [WIDTH-1:0] cand_even, cand_odd;
    logic             cand_even_ok, cand_odd_ok;

    cpe_pred_calc #(.WIDTH(WIDTH)) u_calc (
        .y        (in_data),
        .limit    (limit),
        .even_val (cand_even),
        .even_ok  (cand_even_ok),
        .odd_val  (cand_odd),
        .odd_ok   (cand_odd_ok)
    );

    cpe_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .limit        (limit),
        .in_empty     (in_empty),
        .in_pop       (in_pop),
        .cand_even    (cand_even),
        .cand_even_ok (cand_even_ok),
        .cand_odd     (cand_odd),
        .cand_odd_ok  (cand_odd_ok),
        .out_full     (out_full),
        .out_push     (out_push),
        .out_data     (out_data)
    );

endmodule

// File: tb/test_collatz_pred_engine.sv
// Scoreboard bench: the driver task queues inputs and their expected
// words, and a monitor compares every accepted push against the queue.
module test_collatz_pred_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [31:0] limit = 32'hFFFF_FFFF;
    logic        in_empty;
    logic        in_pop;
    logic [31:0] in_data;
    logic        out_full;
    logic        out_push;
    logic [31:0] out_data;

    int checks = 0;
    int errors = 0;
    int cycle  = 0;
    int pops   = 0;
    int pushes = 0;

    logic [31:0] in_mem [0:255];
    int          wr = 0;
    int          rd;
    logic [31:0] exp_q [$];
    logic        force_full = 1'b0;
    logic        churn = 1'b0;
    logic [7:0]  lfsr;

    always #4 clk = ~clk;

    collatz_pred_engine i_collatz_pred_engine (
        .clk(clk), .rst_n(rst_n), .enable(enable), .limit(limit),
        .in_empty(in_empty), .in_pop(in_pop), .in_data(in_data),
        .out_full(out_full), .out_push(out_push), .out_data(out_data)
    );

    assign in_empty = (rd == wr);

    // Input queue model with one-cycle read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd      <= 0;
            in_data <= '0;
        end else if (in_pop) begin
            in_data <= in_mem[rd[7:0]];
            rd      <= rd + 1;
        end
    end

    // Output backpressure source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr     <= 8'h5A;
            out_full <= 1'b0;
        end else begin
            lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_full <= force_full | (churn & lfsr[0]);
        end
    end

    always @(posedge clk) cycle <= cycle + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: every accepted push must match the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && in_pop) pops++;
        if (rst_n && out_push) begin
            pushes++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R2/R5 unexpected push", out_data, 32'd0);
            end else begin
                check(out_data == exp_q[0], "R1/R2/R3/R5 output word", out_data, exp_q[0]);
                void'(exp_q.pop_front());
            end
        end
    end

    // Driver: queue one input and its expected words in emission order.
    task automatic drive(input logic [31:0] y);
        logic [63:0] e;
        logic [31:0] o;
        e = {32'd0, y} * 64'd2;
        if (e < 64'h1_0000_0000 && e <= {32'd0, limit}) exp_q.push_back(e[31:0]);
        o = (y - 32'd1) / 32'd3;
        if ((y % 32'd6) == 32'd4 && o != 32'd1 && o <= limit) exp_q.push_back(o);
        @(negedge clk);
        in_mem[wr[7:0]] = y;
        wr = wr + 1;
    endtask

    task automatic drain(input int maxc);
        for (int k = 0; k < maxc; k++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && rd == wr) break;
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check(in_pop == 1'b0, "R8 in_pop after reset", 32'(in_pop), 32'd0);
        check(out_push == 1'b0, "R8 out_push after reset", 32'(out_push), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        enable = 1'b1;

        // R1 R2 R3: mixed residues, no backpressure
        drive(32'd1); drive(32'd4); drive(32'd10); drive(32'd7);
        drive(32'd16); drive(32'd0); drive(32'd22); drive(32'd5);
        drain(400);
        check(exp_q.size() == 0, "R3 all words seen", 32'(exp_q.size()), 32'd0);

        // R1: overflow of the doubled word, odd word still emitted
        drive(32'h8000_0000); drive(32'hFFFF_FFFA); drive(32'hFFFF_FFFF);
        drain(200);
        check(exp_q.size() == 0, "R1 overflow cases", 32'(exp_q.size()), 32'd0);

        // R1 R2: bound suppression
        @(negedge clk); limit = 32'd30;
        drive(32'd16); drive(32'd15); drive(32'd100); drive(32'd94);
        drain(200);
        check(exp_q.size() == 0, "R2 bound cases", 32'(exp_q.size()), 32'd0);
        @(negedge clk); limit = 32'hFFFF_FFFF;

        // R6: throughput without backpressure
        begin
            int t0, t1;
            enable = 1'b0;
            for (int k = 0; k < 20; k++) drive(32'd10 + 32'(6 * k));
            @(negedge clk);
            t0 = cycle;
            enable = 1'b1;
            for (int k = 0; k < 400; k++) begin
                @(negedge clk);
                if (exp_q.size() == 0) break;
            end
            t1 = cycle;
            check((t1 - t0) <= 82, "R6 cycles for 20 inputs", 32'(t1 - t0), 32'd82);
        end
        drain(100);

        // R5: random backpressure colliding with both push states
        @(negedge clk); churn = 1'b1;
        for (int k = 0; k < 40; k++) drive(32'd4 + 32'(6 * k) + 32'd6);
        drive(32'd9); drive(32'd28);
        drain(2000);
        check(exp_q.size() == 0, "R5 no loss under stall", 32'(exp_q.size()), 32'd0);
        @(negedge clk); churn = 1'b0;

        // R5: held full, nothing pushed, words kept
        @(negedge clk); force_full = 1'b1;
        drive(32'd22);
        repeat (12) @(negedge clk);
        check(exp_q.size() == 2, "R5 held while full", 32'(exp_q.size()), 32'd2);

        // R7: enable dropped with words pending, they still complete
        enable = 1'b0;
        force_full = 1'b0;
        repeat (12) @(negedge clk);
        check(exp_q.size() == 0, "R7 pending words finished", 32'(exp_q.size()), 32'd0);

        // R7: no pops while disabled
        begin
            int p0, q0;
            p0 = pops; q0 = pushes;
            drive(32'd34); drive(32'd40);
            repeat (15) @(negedge clk);
            check(pops == p0, "R7 no pop while disabled", 32'(pops), 32'(p0));
            check(pushes == q0, "R7 no push while disabled", 32'(pushes), 32'(q0));
            // R4: enable resumes and the queue drains one item at a time
            enable = 1'b1;
            drain(200);
            check(pops == p0 + 2, "R4 pops after enable", 32'(pops), 32'(p0 + 2));
            check(exp_q.size() == 0, "R4 words after enable", 32'(exp_q.size()), 32'd0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycle, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule